// File: doc/BRIEF.md
# Shifter Operand Generator

This block forms the second operand of a data-processing ALU, together with the carry that the shifter produces. It reads the operand field of the instruction word, the value of the register being shifted, the low byte of the register that holds a dynamic shift amount, and the current carry flag. From these it yields a 32-bit operand and a carry-out, both registered, so that the pair is available one clock after the inputs are presented.

There are three operand forms. The first is an 8-bit constant rotated right by an even amount. The second is a register shifted by a 5-bit amount taken from the instruction. The third is a register shifted by an amount held in another register. The shift kinds are logical left, logical right, arithmetic right, rotate right, and a one-bit rotate right through the carry flag, which forms a 33-bit ring. The block reads only instruction bit 25 and instruction bits 11:0, so the condition, opcode, S bit and register numbers are not wired to it. The ALU and the register file sit outside the block.

Top module: `shifter_operand_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, `operand` becomes 0 and `carry_out` becomes 0 after that edge. Otherwise both outputs show, one cycle later, the result for the inputs sampled at that edge.
- R2: With `imm_form`=1, the result is `op2_bits[7:0]`, zero-extended and rotated right by twice `op2_bits[11:8]`. When that rotate count is non-zero, `carry_out` equals bit 31 of the result.
- R3: With `imm_form`=1 and `op2_bits[11:8]`=0, the result is the zero-extended constant and `carry_out` equals `c_in`.
- R4: With `imm_form`=0, `op2_bits[6:5]` selects the kind (00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right). `op2_bits[4]`=0 takes the amount from `op2_bits[11:7]`, and `op2_bits[4]`=1 takes it from `rs_low`.
- R5: Logical shifts fill the vacated positions with zeros, and `carry_out` is the last bit shifted out. A logical left shift by an instruction amount of 0 passes `rm_val` through with `carry_out`=`c_in`.
- R6: An instruction amount of 0 with logical right gives 0, and with arithmetic right gives 32 copies of `rm_val[31]`. In both cases `carry_out`=`rm_val[31]`.
- R7: An instruction amount of 0 with rotate right gives `{c_in, rm_val[31:1]}` with `carry_out`=`rm_val[0]`.
- R8: An arithmetic right shift by 1 to 31 fills the vacated positions with `rm_val[31]`, and `carry_out` is the last bit shifted out.
- R9: With a register amount, `rs_low`=0 passes `rm_val` through with `carry_out`=`c_in`, for every kind.
- R10: With a register amount, a logical left or logical right shift by exactly 32 gives 0 with `carry_out` equal to `rm_val[0]` or `rm_val[31]` respectively. Any amount above 32 gives 0 with `carry_out`=0.
- R11: With a register amount, an arithmetic right shift by 32 or more gives 32 copies of `rm_val[31]` with `carry_out`=`rm_val[31]`.
- R12: With a register amount, rotate right uses `rs_low[4:0]`. A non-zero amount whose low five bits are 0 leaves `rm_val` unchanged with `carry_out`=`rm_val[31]`. Any other non-zero amount gives `carry_out` equal to bit 31 of the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| imm_form | input | 1 | Instruction bit 25: 1 selects the rotated-constant form |
| op2_bits | input | 12 | Instruction bits 11:0, the operand field |
| rm_val | input | 32 | Value of the register that is shifted |
| rs_low | input | 8 | Low byte of the register that holds the shift amount |
| c_in | input | 1 | Current carry flag |
| operand | output | 32 | Registered second ALU operand |
| carry_out | output | 1 | Registered shifter carry |

## Verification
The assertions check the fixed-outcome cases on every cycle against the inputs of the previous cycle. These are the cleared outputs after reset, the constant pass-through and the rotated-constant carry rule, the carry rotate, the zero register amount, and the saturated logical-left and arithmetic-right results for large register amounts. The general shifted values and carries for arbitrary amounts can only be shown by the bench. It compares every result with a bit-serial model that shifts one position at a time, and feeds it directed edge amounts (0, 1, 31, 32, 33, 255) as well as random instruction fields and register values.

// File: rtl/sop_pkg.sv
package sop_pkg;
  typedef enum logic [2:0] {
    SK_LSL = 3'd0,
    SK_LSR = 3'd1,
    SK_ASR = 3'd2,
    SK_ROR = 3'd3,
    SK_RRX = 3'd4
  } shift_kind_t;

  // operand field layout (bit positions inside bits 11:0)
  localparam int FLD_W       = 12;
  localparam int CONST_W     = 8;
  localparam int ROTF_LO     = 8;
  localparam int ROTF_HI     = 11;
  localparam int TYPE_LO     = 5;
  localparam int TYPE_HI     = 6;
  localparam int REGAMT_BIT  = 4;
  localparam int IAMT_LO     = 7;
  localparam int IAMT_HI     = 11;

  function automatic shift_kind_t kind_of(input logic [1:0] t);
    case (t)
      2'b00:   kind_of = SK_LSL;
      2'b01:   kind_of = SK_LSR;
      2'b10:   kind_of = SK_ASR;
      default: kind_of = SK_ROR;
    endcase
  endfunction
endpackage

// File: rtl/sop_decode.sv
module sop_decode
  import sop_pkg::*;
#(
  parameter int DW    = 32,
  parameter int AMT_W = 8
) (
  input  logic              imm_form,
  input  logic [FLD_W-1:0]  fld,
  input  logic [AMT_W-1:0]  rs_amt,
  input  logic [DW-1:0]     rm_val,
  output logic [DW-1:0]     src,
  output shift_kind_t       kind,
  output logic [AMT_W-1:0]  amt
);
  localparam int IAMT_W = IAMT_HI - IAMT_LO + 1;
  localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(DW);

  logic [IAMT_W-1:0] imm_amt;
  logic [1:0]        typ;

  assign imm_amt = fld[IAMT_HI:IAMT_LO];
  assign typ     = fld[TYPE_HI:TYPE_LO];

  always_comb begin
    src  = rm_val;
    kind = kind_of(typ);
    amt  = '0;
    if (imm_form) begin
      // even rotate of a zero-extended constant
      src  = DW'(fld[CONST_W-1:0]);
      kind = SK_ROR;
      amt  = AMT_W'({fld[ROTF_HI:ROTF_LO], 1'b0});
    end else if (fld[REGAMT_BIT]) begin
      amt = rs_amt;
    end else begin
      amt = AMT_W'(imm_amt);
      if (imm_amt == '0) begin
        case (kind_of(typ))
          SK_LSR, SK_ASR: amt = FULL_AMT;
          SK_ROR:         kind = SK_RRX;
          default:        amt = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/sop_shift_core.sv
module sop_shift_core
  import sop_pkg::*;
#(
  parameter int DW    = 32,
  parameter int AMT_W = 8
) (
  input  logic [DW-1:0]    val,
  input  logic             c_in,
  input  shift_kind_t      kind,
  input  logic [AMT_W-1:0] amt,
  output logic [DW-1:0]    res,
  output logic             c_out
);
  // DW must be a power of two so that rotation wraps on the low bits
  localparam int SW = $clog2(DW);
  localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(DW);
  localparam logic [SW:0]      FULL_ROT = (SW+1)'(DW);

  logic [AMT_W-1:0] up_idx;
  logic [AMT_W-1:0] dn_idx;
  logic [SW-1:0]    rot_r;
  logic [DW-1:0]    ror_v;
  logic [DW-1:0]    asr_v;
  logic             amt_zero;

  assign up_idx   = FULL_AMT - amt;
  assign dn_idx   = amt - AMT_W'(1);
  assign rot_r    = amt[SW-1:0];
  assign ror_v    = (val >> rot_r) | (val << (FULL_ROT - {1'b0, rot_r}));
  assign asr_v    = $unsigned($signed(val) >>> amt);
  assign amt_zero = (amt == '0);

  always_comb begin
    res   = val;
    c_out = c_in;
    case (kind)
      SK_LSL: begin
        if (!amt_zero) begin
          if (amt < FULL_AMT) begin
            res   = val << amt;
            c_out = val[up_idx[SW-1:0]];
          end else begin
            res   = '0;
            c_out = (amt == FULL_AMT) ? val[0] : 1'b0;
          end
        end
      end
      SK_LSR: begin
        if (!amt_zero) begin
          if (amt < FULL_AMT) begin
            res   = val >> amt;
            c_out = val[dn_idx[SW-1:0]];
          end else begin
            res   = '0;
            c_out = (amt == FULL_AMT) ? val[DW-1] : 1'b0;
          end
        end
      end
      SK_ASR: begin
        if (!amt_zero) begin
          if (amt < FULL_AMT) begin
            res   = asr_v;
            c_out = val[dn_idx[SW-1:0]];
          end else begin
            res   = {DW{val[DW-1]}};
            c_out = val[DW-1];
          end
        end
      end
      SK_ROR: begin
        if (!amt_zero) begin
          res   = ror_v;
          c_out = ror_v[DW-1];
        end
      end
      SK_RRX: begin
        res   = {c_in, val[DW-1:1]};
        c_out = val[0];
      end
      default: begin
        res   = val;
        c_out = c_in;
      end
    endcase
  end
endmodule

// File: rtl/shifter_operand_gen.sv
module shifter_operand_gen
  import sop_pkg::*;
#(
  parameter int DW    = 32,
  parameter int AMT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             imm_form,
  input  logic [11:0]      op2_bits,
  input  logic [DW-1:0]    rm_val,
  input  logic [AMT_W-1:0] rs_low,
  input  logic             c_in,
  output logic [DW-1:0]    operand,
  output logic             carry_out
);
  logic [DW-1:0]    src;
  shift_kind_t      kind;
  logic [AMT_W-1:0] amt;
  logic [DW-1:0]    res;
  logic             c_nx;

  sop_decode #(.DW(DW), .AMT_W(AMT_W)) u_dec (
    .imm_form (imm_form),
    .fld      (op2_bits),
    .rs_amt   (rs_low),
    .rm_val   (rm_val),
    .src      (src),
    .kind     (kind),
    .amt      (amt)
  );

  sop_shift_core #(.DW(DW), .AMT_W(AMT_W)) u_core (
    .val   (src),
    .c_in  (c_in),
    .kind  (kind),
    .amt   (amt),
    .res   (res),
    .c_out (c_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      operand   <= '0;
      carry_out <= 1'b0;
    end else begin
      operand   <= res;
      carry_out <= c_nx;
    end
  end
endmodule

// File: rtl/sop_checker.sv
module sop_checker #(
  parameter int DW    = 32,
  parameter int AMT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             imm_form,
  input logic [11:0]      op2_bits,
  input logic [DW-1:0]    rm_val,
  input logic [AMT_W-1:0] rs_low,
  input logic             c_in,
  input logic [DW-1:0]    operand,
  input logic             carry_out
);
  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (operand == '0 && !carry_out));

  p_const_pass_r3: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(imm_form) && $past(op2_bits[11:8]) == 4'd0)
    |-> (operand == DW'($past(op2_bits[7:0])) && carry_out == $past(c_in)));

  p_const_carry_r2: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(imm_form) && $past(op2_bits[11:8]) != 4'd0)
    |-> (carry_out == operand[DW-1]));

  p_rrx_ring_r7: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(imm_form) && $past(op2_bits[11:4]) == 8'h06)
    |-> (operand == {$past(c_in), $past(rm_val[DW-1:1])} && carry_out == $past(rm_val[0])));

  p_regamt_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(imm_form) && $past(op2_bits[4]) && $past(rs_low) == '0)
    |-> (operand == $past(rm_val) && carry_out == $past(c_in)));

  p_lsl_over_r10: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(imm_form) && $past(op2_bits[4]) && $past(op2_bits[6:5]) == 2'b00
     && $past(rs_low) > AMT_W'(DW))
    |-> (operand == '0 && !carry_out));

  p_asr_sat_r11: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(imm_form) && $past(op2_bits[4]) && $past(op2_bits[6:5]) == 2'b10
     && $past(rs_low) >= AMT_W'(DW))
    |-> (operand == {DW{$past(rm_val[DW-1])}} && carry_out == $past(rm_val[DW-1])));
endmodule

bind shifter_operand_gen sop_checker #(.DW(DW), .AMT_W(AMT_W)) u_sop_chk (
  .clk       (clk),
  .rst       (rst),
  .imm_form  (imm_form),
  .op2_bits  (op2_bits),
  .rm_val    (rm_val),
  .rs_low    (rs_low),
  .c_in      (c_in),
  .operand   (operand),
  .carry_out (carry_out)
);

// File: tb/shifter_operand_gen_test.sv
module shifter_operand_gen_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        imm_form = 1'b0;
  logic [11:0] op2_bits = '0;
  logic [31:0] rm_val = '0;
  logic [7:0]  rs_low = '0;
  logic        c_in = 1'b0;
  logic [31:0] operand;
  logic        carry_out;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shifter_operand_gen uut (
    .clk(clk), .rst(rst), .imm_form(imm_form), .op2_bits(op2_bits),
    .rm_val(rm_val), .rs_low(rs_low), .c_in(c_in),
    .operand(operand), .carry_out(carry_out)
  );

  // bit-serial model: one position per step, carry = bit that left last
  function automatic logic [32:0] model(input logic im, input logic [11:0] f,
                                        input logic [31:0] rm, input logic [7:0] rs,
                                        input logic ci);
    logic [31:0] v;
    logic        cc;
    int          n;
    logic [1:0]  t;
    cc = ci;
    if (im) begin
      v = {24'd0, f[7:0]};
      n = 2 * int'(f[11:8]);
      for (int i = 0; i < n; i++) begin
        cc = v[0];
        v  = {v[0], v[31:1]};
      end
      return {cc, v};
    end
    v = rm;
    t = f[6:5];
    if (f[4]) n = int'(rs);
    else begin
      n = int'(f[11:7]);
      if (n == 0) begin
        if (t == 2'b01 || t == 2'b10) n = 32;
        else if (t == 2'b11) return {rm[0], ci, rm[31:1]};
      end
    end
    for (int i = 0; i < n; i++) begin
      case (t)
        2'b00: begin cc = v[31]; v = {v[30:0], 1'b0}; end
        2'b01: begin cc = v[0];  v = {1'b0, v[31:1]}; end
        2'b10: begin cc = v[0];  v = {v[31], v[31:1]}; end
        default: begin cc = v[0]; v = {v[0], v[31:1]}; end
      endcase
    end
    return {cc, v};
  endfunction

  task automatic check(input string req, input logic [32:0] exp);
    total++;
    if ({carry_out, operand} !== exp) begin
      bad++;
      $display("FAIL %s: got op=%h c=%b, expected op=%h c=%b",
               req, operand, carry_out, exp[31:0], exp[32]);
    end
  endtask

  task automatic run(input string req, input logic im, input logic [11:0] f,
                     input logic [31:0] rm, input logic [7:0] rs, input logic ci);
    @(negedge clk);
    imm_form = im; op2_bits = f; rm_val = rm; rs_low = rs; c_in = ci;
    @(negedge clk);
    check(req, model(im, f, rm, rs, ci));
  endtask

  function automatic logic [11:0] fi(input logic [4:0] a, input logic [1:0] t);
    return {a, t, 1'b0, 4'd3};
  endfunction
  function automatic logic [11:0] fr(input logic [1:0] t);
    return {4'd5, 1'b0, t, 1'b1, 4'd3};
  endfunction

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset clears outputs even with live inputs
    imm_form = 1'b1; op2_bits = 12'h0FF; c_in = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", 33'd0);
    rst = 1'b0;

    // R2 / R3 immediate form
    run("R3", 1'b1, 12'h0A5, 32'hFFFF_FFFF, 8'd0, 1'b1);
    run("R3", 1'b1, 12'h07F, 32'h0, 8'd0, 1'b0);
    run("R2", 1'b1, 12'h1FF, 32'h0, 8'd0, 1'b0);
    run("R2", 1'b1, 12'h4C3, 32'h0, 8'd0, 1'b1);
    run("R2", 1'b1, 12'hF01, 32'h0, 8'd0, 1'b1);
    run("R2", 1'b1, 12'h802, 32'h0, 8'd0, 1'b0);
    // R4 / R5 logical shifts with instruction amounts
    run("R5", 1'b0, fi(5'd0, 2'b00), 32'h8000_0001, 8'd0, 1'b1);
    run("R5", 1'b0, fi(5'd1, 2'b00), 32'h8000_0001, 8'd0, 1'b0);
    run("R5", 1'b0, fi(5'd31, 2'b00), 32'h0000_0003, 8'd0, 1'b0);
    run("R5", 1'b0, fi(5'd4, 2'b01), 32'h1234_5678, 8'd0, 1'b0);
    run("R4", 1'b0, fi(5'd31, 2'b01), 32'hC000_0000, 8'd0, 1'b0);
    // R6 amount 0 means 32
    run("R6", 1'b0, fi(5'd0, 2'b01), 32'h8000_0000, 8'd0, 1'b0);
    run("R6", 1'b0, fi(5'd0, 2'b10), 32'h8000_0000, 8'd0, 1'b0);
    run("R6", 1'b0, fi(5'd0, 2'b10), 32'h7FFF_FFFF, 8'd0, 1'b1);
    // R7 rotate through carry
    run("R7", 1'b0, fi(5'd0, 2'b11), 32'h0000_0003, 8'd0, 1'b1);
    run("R7", 1'b0, fi(5'd0, 2'b11), 32'hFFFF_FFFE, 8'd0, 1'b0);
    // R8 arithmetic right
    run("R8", 1'b0, fi(5'd1, 2'b10), 32'h8000_0001, 8'd0, 1'b0);
    run("R8", 1'b0, fi(5'd31, 2'b10), 32'hC000_0000, 8'd0, 1'b0);
    run("R8", 1'b0, fi(5'd5, 2'b10), 32'h7000_0010, 8'd0, 1'b0);
    // R9 register amount of zero
    for (int t = 0; t < 4; t++)
      run("R9", 1'b0, fr(2'(t)), 32'hDEAD_BEEF, 8'd0, 1'(t & 1));
    // R10 logical at and above 32
    run("R10", 1'b0, fr(2'b00), 32'h0000_0001, 8'd32, 1'b0);
    run("R10", 1'b0, fr(2'b01), 32'h8000_0000, 8'd32, 1'b0);
    run("R10", 1'b0, fr(2'b00), 32'hFFFF_FFFF, 8'd33, 1'b1);
    run("R10", 1'b0, fr(2'b01), 32'hFFFF_FFFF, 8'd255, 1'b1);
    // R11 arithmetic at and above 32
    run("R11", 1'b0, fr(2'b10), 32'h8000_0000, 8'd32, 1'b0);
    run("R11", 1'b0, fr(2'b10), 32'h7FFF_FFFF, 8'd200, 1'b1);
    // R12 register rotate
    run("R12", 1'b0, fr(2'b11), 32'h8000_0001, 8'd32, 1'b0);
    run("R12", 1'b0, fr(2'b11), 32'h0000_0001, 8'd64, 1'b1);
    run("R12", 1'b0, fr(2'b11), 32'h0000_00F0, 8'd36, 1'b0);
    run("R12", 1'b0, fr(2'b11), 32'h1234_5678, 8'd1, 1'b0);

    // R4 random mix over all forms
    void'($urandom(32'd20240611));
    for (int k = 0; k < 3000; k++) begin
      logic [7:0] rs;
      rs = 8'($urandom);
      if ((k % 3) == 0) rs = 8'(rs % 40);
      run("R4", 1'($urandom), 12'($urandom), $urandom, rs, 1'($urandom));
    end

    // R1 again: reset mid-run
    @(negedge clk);
    rst = 1'b1; imm_form = 1'b1; op2_bits = 12'h0FF;
    @(negedge clk);
    check("R1", 33'd0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule